// File: doc/BRIEF.md
# Processor Sleep-Entry Sequencer

This block orders the processor clock-stop and sleep signals when the platform goes into a light sleep state. It also produces the processor power-good output. A sleep-entry request pulls the active-low stop-clock output low. One stop-clock output serves both processors. The block then waits for a stop-grant acknowledge from the host. The first acknowledge starts a fixed delay measured in PCI clocks. When the delay has run out and the sleep-enable bit is 1, the active-low sleep output is driven low.

Acknowledges carry no processor identity, so the block cannot count them per processor. Instead it waits from the first acknowledge for a fixed minimum time, which leaves room for the second processor to acknowledge. A wake request undoes the sequence in reverse order. Sleep is released first, stop-clock is released one clock later, and the sequencer then returns to idle.

The power-good output is the AND of the supply-good and regulator-good inputs. It is forced high while a processor speed-state change is in progress, so that the processor keeps its context.

Top module: `cpu_sleep_seq`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, stopClkN and sleepN are both 1, where 1 is the inactive level of both outputs. The delay counter starts from zero, so any later sleep still needs the full delay.
- R2: In idle, sleepReq=1 drives stopClkN to 0 at the next clock edge and leaves sleepN at 1.
- R3: Call the edge that first samples stopGrant=1 after stop-clock went low edge E0. sleepN stays 1 through edge E(WAIT_CLKS) and goes to 0 at edge E(WAIT_CLKS+1), provided sleepEnable=1. That is no sooner than WAIT_CLKS clocks after the first acknowledge.
- R4: Further stopGrant pulses that arrive during the wait are ignored and do not restart the count. The edge at which sleepN falls does not move.
- R5: If sleepEnable=0 when the delay has run out, sleepN stays 1 and stopClkN stays 0. The counter holds at its limit, so raising sleepEnable later drives sleepN to 0 at the next edge.
- R6: wakeReq=1 in any non-idle state sets sleepN to 1 at the next edge and stopClkN to 1 at the edge after that. The sequencer then accepts a new sleepReq.
- R7: With speedTransition=0, cpuPowerGood equals supplyGood AND regGood.
- R8: With speedTransition=1, cpuPowerGood is 1 whatever the supply inputs are.
- R9: stopGrant pulses received while idle have no effect. stopClkN stays 1, and a later sleep entry still waits the full delay from its own first acknowledge.
- R10: In idle, wakeReq takes priority over sleepReq. When both are 1, stopClkN stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | Request to enter the light sleep state |
| sleepEnable | input | 1 | Allows the sleep output to be asserted |
| stopGrant | input | 1 | One-cycle stop-grant acknowledge seen on the host bus |
| wakeReq | input | 1 | Request to leave the sleep state |
| supplyGood | input | 1 | Platform supply is good |
| regGood | input | 1 | Processor voltage regulator is good |
| speedTransition | input | 1 | Processor speed-state change in progress |
| stopClkN | output | 1 | Active-low stop-clock to both processors |
| sleepN | output | 1 | Active-low processor sleep |
| cpuPowerGood | output | 1 | Processor power-good |

## Verification
The case hardest to reach from the ports is a second acknowledge landing at each possible point in the wait, because a faulty design that restarted the count would still assert sleep, only late. The bench sweeps the extra acknowledge across every cycle of a shortened wait and checks sleep on every clock edge. It also varies the gap between stop-clock and the first acknowledge. A further run holds sleep-enable low so that the counter sits saturated at its limit before enable rises.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAITGNT = 3'd1,
    ST_COUNT   = 3'd2,
    ST_SLEEP   = 3'd3,
    ST_WAKE    = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic setStop;
    logic clrStop;
    logic setSleep;
    logic clrSleep;
  } seqStrobes_t;

endpackage

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleepReq,
  input  logic        sleepEnable,
  input  logic        stopGrant,
  input  logic        wakeReq,
  input  logic        cntDone,
  output seqStrobes_t strobes
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        // wake has priority over a simultaneous entry request
        if (sleepReq && !wakeReq) begin
          strobes.setStop = 1'b1;
          strobes.clrCnt  = 1'b1;
          stateNext       = ST_WAITGNT;
        end
      end
      ST_WAITGNT: begin
        if (wakeReq) begin
          strobes.clrSleep = 1'b1;
          stateNext        = ST_WAKE;
        end else if (stopGrant) begin
          strobes.clrCnt = 1'b1;
          stateNext      = ST_COUNT;
        end
      end
      ST_COUNT: begin
        // later acknowledges are not looked at here
        if (wakeReq) begin
          strobes.clrSleep = 1'b1;
          stateNext        = ST_WAKE;
        end else if (cntDone && sleepEnable) begin
          strobes.setSleep = 1'b1;
          stateNext        = ST_SLEEP;
        end else begin
          strobes.incCnt = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wakeReq) begin
          strobes.clrSleep = 1'b1;
          stateNext        = ST_WAKE;
        end
      end
      ST_WAKE: begin
        strobes.clrStop = 1'b1;
        strobes.clrCnt  = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sleep_seq_dpath.sv
module sleep_seq_dpath
  import sleep_seq_pkg::*;
#(
  parameter int WAIT_CLKS = 60,
  parameter int CNT_W     = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seqStrobes_t strobes,
  input  logic        supplyGood,
  input  logic        regGood,
  input  logic        speedTransition,
  output logic        cntDone,
  output logic        stopClkN,
  output logic        sleepN,
  output logic        cpuPowerGood
);

  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(WAIT_CLKS);

  logic [CNT_W-1:0] waitCnt;

  assign cntDone = (waitCnt == CNT_LIMIT);

  // saturating delay counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           waitCnt <= '0;
    else if (strobes.clrCnt)              waitCnt <= '0;
    else if (strobes.incCnt && !cntDone)  waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stopClkN <= 1'b1;
    else if (strobes.setStop)  stopClkN <= 1'b0;
    else if (strobes.clrStop)  stopClkN <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sleepN <= 1'b1;
    else if (strobes.clrSleep)  sleepN <= 1'b1;
    else if (strobes.setSleep)  sleepN <= 1'b0;
  end

  assign cpuPowerGood = speedTransition | (supplyGood & regGood);

endmodule

// File: rtl/cpu_sleep_seq.sv
module cpu_sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int WAIT_CLKS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleepReq,
  input  logic sleepEnable,
  input  logic stopGrant,
  input  logic wakeReq,
  input  logic supplyGood,
  input  logic regGood,
  input  logic speedTransition,
  output logic stopClkN,
  output logic sleepN,
  output logic cpuPowerGood
);

  localparam int CNT_BITS = $clog2(WAIT_CLKS + 1);
  localparam int CNT_W    = (CNT_BITS > 6) ? CNT_BITS : 6;

  seqStrobes_t strobes;
  logic        cntDone;

  sleep_seq_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleepReq    (sleepReq),
    .sleepEnable (sleepEnable),
    .stopGrant   (stopGrant),
    .wakeReq     (wakeReq),
    .cntDone     (cntDone),
    .strobes     (strobes)
  );

  sleep_seq_dpath #(
    .WAIT_CLKS (WAIT_CLKS),
    .CNT_W     (CNT_W)
  ) dpath_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobes         (strobes),
    .supplyGood      (supplyGood),
    .regGood         (regGood),
    .speedTransition (speedTransition),
    .cntDone         (cntDone),
    .stopClkN        (stopClkN),
    .sleepN          (sleepN),
    .cpuPowerGood    (cpuPowerGood)
  );

endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int WAIT_CLKS = 60
) (
  input logic clk,
  input logic rst_n,
  input logic sleepEnable,
  input logic stopGrant,
  input logic wakeReq,
  input logic supplyGood,
  input logic regGood,
  input logic speedTransition,
  input logic stopClkN,
  input logic sleepN,
  input logic cpuPowerGood
);

  localparam int CW = $clog2(WAIT_CLKS + 2) + 1;
  localparam logic [CW-1:0] CAP = CW'(WAIT_CLKS + 1);

  // cycles since the first acknowledge seen while stop-clock is low
  logic          gntSeen;
  logic [CW-1:0] sinceGnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gntSeen  <= 1'b0;
      sinceGnt <= '0;
    end else if (stopClkN) begin
      gntSeen  <= 1'b0;
      sinceGnt <= '0;
    end else if (!gntSeen && stopGrant) begin
      gntSeen  <= 1'b1;
      sinceGnt <= '0;
    end else if (gntSeen && sinceGnt < CAP) begin
      sinceGnt <= sinceGnt + 1'b1;
    end
  end

  p_sleep_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleepN) |-> (gntSeen && sinceGnt >= CW'(WAIT_CLKS)));

  p_sleep_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleepN) |-> $past(sleepEnable));

  p_sleep_inside_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sleepN |-> !stopClkN);

  p_wake_drops_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeReq && !stopClkN) |=> sleepN);

  p_release_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopClkN) |-> ($past(sleepN) && sleepN));

  p_pg_high_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (supplyGood && regGood) |-> cpuPowerGood);

  p_pg_low_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!supplyGood && !speedTransition) |-> !cpuPowerGood);

  p_pg_low_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!regGood && !speedTransition) |-> !cpuPowerGood);

  p_pg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    speedTransition |-> cpuPowerGood);

endmodule

bind cpu_sleep_seq sleep_seq_chk #(.WAIT_CLKS(WAIT_CLKS)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .sleepEnable     (sleepEnable),
  .stopGrant       (stopGrant),
  .wakeReq         (wakeReq),
  .supplyGood      (supplyGood),
  .regGood         (regGood),
  .speedTransition (speedTransition),
  .stopClkN        (stopClkN),
  .sleepN          (sleepN),
  .cpuPowerGood    (cpuPowerGood)
);

// File: tb/cpu_sleep_seq_tb_top.sv
`timescale 1ns/1ps
module cpu_sleep_seq_tb_top;

  localparam int WAIT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepReq = 0, sleepEnable = 0, stopGrant = 0, wakeReq = 0;
  logic supplyGood = 0, regGood = 0, speedTransition = 0;
  logic stopClkN, sleepN, cpuPowerGood;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cpu_sleep_seq #(.WAIT_CLKS(WAIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .sleepEnable(sleepEnable),
    .stopGrant(stopGrant), .wakeReq(wakeReq), .supplyGood(supplyGood),
    .regGood(regGood), .speedTransition(speedTransition),
    .stopClkN(stopClkN), .sleepN(sleepN), .cpuPowerGood(cpuPowerGood)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doWake();
    wakeReq = 1; step();
    chk(sleepN, 1'b1, "R6 sleep released first");
    chk(stopClkN, 1'b0, "R6 stop still held one clock");
    wakeReq = 0; step();
    chk(stopClkN, 1'b1, "R6 stop released");
  endtask

  // full entry: gap cycles before first grant, extra grant at offset x (0 = none)
  task automatic entry(input int gap, input int x, input logic en);
    sleepEnable = en;
    sleepReq = 1; step(); sleepReq = 0;
    chk(stopClkN, 1'b0, "R2 stop asserted");
    chk(sleepN, 1'b1, "R2 sleep still high");
    for (int g = 0; g < gap; g++) begin
      step();
      chk(sleepN, 1'b1, "R3 no sleep before grant");
    end
    stopGrant = 1; step(); stopGrant = 0;
    for (int k = 1; k <= WAIT; k++) begin
      stopGrant = (k == x);
      step();
      chk(sleepN, 1'b1, x != 0 ? "R4 sleep high during wait" : "R3 sleep high during wait");
    end
    stopGrant = 0;
    step();
    if (en) begin
      chk(sleepN, 1'b0, x != 0 ? "R4 sleep edge unchanged" : "R3 sleep asserted on time");
    end else begin
      chk(sleepN, 1'b1, "R5 sleep held off by enable");
      for (int j = 0; j < 3; j++) begin
        step();
        chk(sleepN, 1'b1, "R5 sleep stays high");
        chk(stopClkN, 1'b0, "R5 stop stays low");
      end
      sleepEnable = 1; step();
      chk(sleepN, 1'b0, "R5 sleep on late enable");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(stopClkN, 1'b1, "R1 stop high in reset");
    chk(sleepN, 1'b1, "R1 sleep high in reset");
    rst_n = 1; step();
    chk(stopClkN, 1'b1, "R1 stop high after reset");
    chk(sleepN, 1'b1, "R1 sleep high after reset");

    // R7/R8 power-good sweep
    for (int v = 0; v < 8; v++) begin
      {speedTransition, supplyGood, regGood} = 3'(v);
      #1;
      chk(cpuPowerGood, speedTransition | (supplyGood & regGood),
          speedTransition ? "R8 power-good held" : "R7 power-good AND");
    end
    {speedTransition, supplyGood, regGood} = 3'b011;

    // R10 wake priority in idle
    sleepReq = 1; wakeReq = 1; step();
    chk(stopClkN, 1'b1, "R10 wake beats entry");
    sleepReq = 0; wakeReq = 0; step();

    // R9 grants while idle
    for (int i = 0; i < 4; i++) begin
      stopGrant = 1; step();
      chk(stopClkN, 1'b1, "R9 idle grant ignored");
    end
    stopGrant = 0;

    // sweep gap and extra-grant position
    for (int gap = 0; gap < 3; gap++)
      for (int x = 0; x <= WAIT; x++) begin
        entry(gap, x, 1'b1);
        doWake();
        step();
      end

    // enable low at threshold
    entry(1, 0, 1'b0);
    doWake();

    // wake during count
    sleepEnable = 1;
    sleepReq = 1; step(); sleepReq = 0;
    stopGrant = 1; step(); stopGrant = 0;
    repeat (4) step();
    doWake();

    // reset mid-sleep, then a full wait is still needed (R1)
    entry(0, 0, 1'b1);
    rst_n = 0; #1;
    chk(stopClkN, 1'b1, "R1 stop high on reset");
    chk(sleepN, 1'b1, "R1 sleep high on reset");
    step(); rst_n = 1; step();
    entry(2, 3, 1'b1);
    doWake();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule